// File: doc/BRIEF.md
# Dual-Field Montgomery Word Step Unit

This block performs one radix-2 Montgomery reduction step on a single word slice per clock. An outer sequencer feeds it one multiplier bit, plus one word each of the multiplicand, the modulus and the running partial result. In the same cycle the unit adds the multiplicand word when the multiplier bit is set. It then adds the modulus word when the reduction bit is set, and halves the total. Words arrive least significant first, and a first-word strobe marks the start of every operand. The caller appends one all-zero word after the top word so that the last shifted word can be completed.

A single field-select input picks the arithmetic. With it high, every adder cell is a full adder and the partial result is kept redundant, as a sum vector plus a carry vector whose total is the value. With it low, every cell has its carry forced to zero, so the same datapath does carry-less polynomial arithmetic. The reduction bit is formed on the first word from the low bit of the partial result after the multiplicand is added, and is then held for the remaining words. The right shift needs bit 0 of the following word, so each output word is presented one cycle after the input word that completes it.

Top module: `dual_field_mont_pu`

## Requirements
- R1: With `gf_prime`=1, for an operand of N words plus one zero pad word, the integer total of the collected `res_sum` words plus the collected `res_carry` words equals (C + a·B + q·P)/2. Here C = sum part + carry part, and q = (C + a·B) mod 2. Output word j-1 is weighted by 2^(W·(j-1)).
- R2: `q_bit` takes bit 0 of the partial result after the multiplicand addition on the cycle after a first word is accepted. It keeps that value while the later words of the same operand are accepted.
- R3: With `gf_prime`=0, the collected `res_sum` equals (C xor a·B xor q·P) shifted right by one, where C = sum part xor carry part and q is bit 0 of (C xor a·B). Every `res_carry` word is zero.
- R4: With `a_bit`=0, the multiplicand word has no effect: the result equals (C + q·P)/2, with q = C mod 2 (integer mode) or the polynomial equivalent.
- R5: A word accepted with `word_first`=0 gives `res_vld`=1 one cycle later, carrying the shifted word of the previous position. A word accepted with `word_first`=1 gives `res_vld`=0 one cycle later.
- R6: A first-word strobe discards carry state left from the previous operand, so operands issued back to back give the same results as isolated ones.
- R7: After a clock with `rst_n`=0, `res_vld`, `res_sum`, `res_carry` and `q_bit` are all zero.
- R8: Repeating the integer step over the 16 bits of A, with the result fed back as the next partial result starting from zero, gives a value R with R·2^16 ≡ A·B (mod P) for odd P.
- R9: Repeating the polynomial step over the 16 bits of A gives R(x) with R(x)·x^16 ≡ A(x)·B(x) modulo P(x), for a degree-16 P(x) with constant term 1.
- R10: A cycle with `word_vld`=0 changes no state: `res_vld` is 0 one cycle later, and `q_bit` and `res_sum` hold. Idle cycles inserted between words leave the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | Input word present this cycle |
| word_first | input | 1 | Input word is the least significant word of an operand |
| gf_prime | input | 1 | 1 = integer (prime field) arithmetic, 0 = carry-less (binary field) |
| a_bit | input | 1 | Multiplier bit for this operand |
| b_word | input | W | Multiplicand word |
| p_word | input | W | Modulus word |
| cs_word | input | W | Partial result word, sum part |
| cc_word | input | W | Partial result word, carry part |
| res_vld | output | 1 | Output words hold a new shifted result word |
| res_sum | output | W | Shifted result word, sum part |
| res_carry | output | W | Shifted result word, carry part |
| q_bit | output | 1 | Latched reduction bit of the current operand |

## Verification
The delicate overlap is a new operand's first word arriving in the cycle right after the previous operand's pad word. In that cycle the word-to-word carries and the held shift bits of the old operand sit in the registers while the new reduction bit is being formed. The bench issues operands back to back with no idle cycle and compares every result with its own arithmetic model. Any carry that leaks across the boundary corrupts the low word of the new result. Random idle gaps are also placed between words, and the results must not change.

// File: rtl/mont_pkg.sv
// Shared definitions for the dual-field Montgomery word step unit.
// Assumes nothing beyond a single field-select bit per cycle.
package mont_pkg;

    // Arithmetic selected by the field-select input.
    typedef enum logic {
        FLD_BIN   = 1'b0,   // carry-less, carries forced to zero
        FLD_PRIME = 1'b1    // ordinary integer addition
    } fld_e;

    // Smallest word width for which the shift/forwarding logic is valid.
    localparam int unsigned MIN_WORD_W = 2;

endpackage

// File: rtl/mont_dfa_cell.sv
// One dual-field adder bit: a full adder whose carry output is gated by
// the field-select. Assumes prime_en is stable for the cycle.
module mont_dfa_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    input  logic prime_en,
    output logic sum,
    output logic carry
);

    // Sum is the three-way parity in both fields; carry exists only in integer mode.
    always_comb begin
        sum   = x ^ y ^ z;
        carry = prime_en & ((x & y) | (x & z) | (y & z));
    end

endmodule

// File: rtl/mont_csa_stage.sv
// One carry-save compression stage for a W-bit word slice. Three vectors
// are reduced to a sum vector and a carry vector; the carry vector is
// moved up one bit, taking carry_in (top carry of the previous word) at
// bit 0 and handing its own top carry out on carry_top.
// Assumes W >= 2.
module mont_csa_stage #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         prime_en,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry_sh,
    output logic         carry_top
);

    logic [W-1:0] carry_raw;

    // One dual-field cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        mont_dfa_cell u_cell (
            .x        (x[i]),
            .y        (y[i]),
            .z        (z[i]),
            .prime_en (prime_en),
            .sum      (sum[i]),
            .carry    (carry_raw[i])
        );
    end

    // Align carries to their true weight and export the word-crossing bit.
    always_comb begin
        carry_sh  = {carry_raw[W-2:0], carry_in};
        carry_top = carry_raw[W-1];
    end

endmodule

// File: rtl/dual_field_mont_pu.sv
// Dual-field radix-2 Montgomery word step unit.
// Per accepted word: T = C + a*B (stage 1), then T + q*P (stage 2), with
// q formed on the first word and held for the rest of the operand. The
// result is halved by a right shift that pulls bit 0 of the next word into
// the top of the current one, so each output word appears one cycle after
// the input word that completes it. The caller appends one zero pad word.
// Assumes P is odd (integer) or has constant term 1 (polynomial).
module dual_field_mont_pu
    import mont_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_vld,
    input  logic         word_first,
    input  logic         gf_prime,
    input  logic         a_bit,
    input  logic [W-1:0] b_word,
    input  logic [W-1:0] p_word,
    input  logic [W-1:0] cs_word,
    input  logic [W-1:0] cc_word,
    output logic         res_vld,
    output logic [W-1:0] res_sum,
    output logic [W-1:0] res_carry,
    output logic         q_bit
);

    localparam int unsigned HW = W - 1;   // bits held for the shift

    logic          prime_en;
    logic [W-1:0]  add_b;
    logic [W-1:0]  add_p;
    logic          u_cin, v_cin;
    logic [W-1:0]  t_sum, u_sh;
    logic          u_top;
    logic [W-1:0]  s2_sum, v_sh;
    logic          v_top;
    logic          q_now;
    logic          u_reg, v_reg, q_reg;
    logic [HW-1:0] hold_s, hold_c;

    // Decode the field select into the cell carry enable.
    always_comb prime_en = (fld_e'(gf_prime) == FLD_PRIME);

    // Word-crossing carries restart from zero on the first word of an operand.
    always_comb begin
        u_cin = word_first ? 1'b0 : u_reg;
        v_cin = word_first ? 1'b0 : v_reg;
    end

    // Gate the multiplicand by the multiplier bit.
    always_comb add_b = a_bit ? b_word : '0;

    mont_csa_stage #(.W(W)) u_stage_b (
        .x         (cs_word),
        .y         (cc_word),
        .z         (add_b),
        .prime_en  (prime_en),
        .carry_in  (u_cin),
        .sum       (t_sum),
        .carry_sh  (u_sh),
        .carry_top (u_top)
    );

    // Reduction bit: parity of the intermediate on word 0, held afterwards.
    always_comb q_now = word_first ? (t_sum[0] ^ u_sh[0]) : q_reg;

    // Gate the modulus by the reduction bit.
    always_comb add_p = q_now ? p_word : '0;

    mont_csa_stage #(.W(W)) u_stage_p (
        .x         (t_sum),
        .y         (u_sh),
        .z         (add_p),
        .prime_en  (prime_en),
        .carry_in  (v_cin),
        .sum       (s2_sum),
        .carry_sh  (v_sh),
        .carry_top (v_top)
    );

    // Carry, reduction-bit and shift-hold state, advanced on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_reg  <= 1'b0;
            v_reg  <= 1'b0;
            q_reg  <= 1'b0;
            hold_s <= '0;
            hold_c <= '0;
        end else if (word_vld) begin
            u_reg  <= u_top;
            v_reg  <= v_top;
            q_reg  <= q_now;
            hold_s <= s2_sum[W-1:1];
            hold_c <= v_sh[W-1:1];
        end
    end

    // Output word: previous upper bits topped with bit 0 of the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld   <= 1'b0;
            res_sum   <= '0;
            res_carry <= '0;
        end else begin
            res_vld <= word_vld & ~word_first;
            if (word_vld && !word_first) begin
                res_sum   <= {s2_sum[0], hold_s};
                res_carry <= {v_sh[0], hold_c};
            end
        end
    end

    always_comb q_bit = q_reg;

endmodule

// File: rtl/dual_field_mont_pu_chk.sv
// Property checker for dual_field_mont_pu, attached with bind below.
module dual_field_mont_pu_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         word_vld,
    input logic         word_first,
    input logic         gf_prime,
    input logic         a_bit,
    input logic         b_lsb,
    input logic         cs_lsb,
    input logic         cc_lsb,
    input logic         res_vld,
    input logic [W-1:0] res_sum,
    input logic [W-1:0] res_carry,
    input logic         q_bit
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && res_sum == '0 && res_carry == '0 && !q_bit)); // R7

    AST_OUT_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !word_first |=> res_vld); // R5

    AST_NO_OUT_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && word_first |=> !res_vld); // R5

    AST_Q_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && word_first && !gf_prime |=>
            q_bit == $past(cs_lsb ^ cc_lsb ^ (a_bit & b_lsb))); // R2

    AST_Q_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !word_first |=> $stable(q_bit)); // R2

    AST_BIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !word_first && !gf_prime |=> res_carry == '0); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> (!res_vld && $stable(q_bit) && $stable(res_sum))); // R10

endmodule

bind dual_field_mont_pu dual_field_mont_pu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_first (word_first),
    .gf_prime   (gf_prime),
    .a_bit      (a_bit),
    .b_lsb      (b_word[0]),
    .cs_lsb     (cs_word[0]),
    .cc_lsb     (cc_word[0]),
    .res_vld    (res_vld),
    .res_sum    (res_sum),
    .res_carry  (res_carry),
    .q_bit      (q_bit)
);

// File: tb/dual_field_mont_pu_test.sv
`timescale 1ns/1ps
module dual_field_mont_pu_test;

    localparam int W = 8;
    localparam int N = 4;              // data words; one pad word follows

    logic         clk = 1'b0;
    logic         rst_n;
    logic         word_vld, word_first, gf_prime, a_bit;
    logic [W-1:0] b_word, p_word, cs_word, cc_word;
    logic         res_vld;
    logic [W-1:0] res_sum, res_carry;
    logic         q_bit;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;              // 250 MHz

    dual_field_mont_pu #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_first(word_first),
        .gf_prime(gf_prime), .a_bit(a_bit), .b_word(b_word), .p_word(p_word),
        .cs_word(cs_word), .cc_word(cc_word), .res_vld(res_vld),
        .res_sum(res_sum), .res_carry(res_carry), .q_bit(q_bit)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint clmul(input longint x, input longint y);
        longint r = 0;
        for (int i = 0; i < 32; i++) if (y[i]) r ^= (x << i);
        return r;
    endfunction

    function automatic longint pmod(input longint x, input longint p, input int deg);
        longint r = x;
        for (int i = 62; i >= deg; i--) if (r[i]) r ^= (p << (i - deg));
        return r;
    endfunction

    // Issue one operand (N words + pad); collect the shifted result.
    task automatic run_op(input bit gfp, input bit a, input longint cs, input longint cc,
                          input longint b, input longint p, input int gap,
                          output longint rs, output longint rc, output bit q);
        rs = 0; rc = 0; q = 0;
        for (int j = 0; j <= N; j++) begin
            word_vld = 1'b1; word_first = (j == 0); gf_prime = gfp; a_bit = a;
            b_word  = W'(b  >> (W * j));
            p_word  = W'(p  >> (W * j));
            cs_word = W'(cs >> (W * j));
            cc_word = W'(cc >> (W * j));
            @(negedge clk);
            if (j == 0) begin
                q = q_bit;
                chk(res_vld == 1'b0, "R5 no output after first word", longint'(res_vld), 0);
            end else begin
                chk(res_vld == 1'b1, "R5 output after later word", longint'(res_vld), 1);
                chk(q_bit == q, "R2 q held", longint'(q_bit), longint'(q));
                rs |= longint'(res_sum)   << (W * (j - 1));
                rc |= longint'(res_carry) << (W * (j - 1));
            end
            for (int g = 0; g < gap; g++) begin
                word_vld = 1'b0; word_first = $urandom_range(0, 1);
                a_bit = $urandom_range(0, 1);
                b_word = W'($urandom); p_word = W'($urandom);
                cs_word = W'($urandom); cc_word = W'($urandom);
                @(negedge clk);
                chk(res_vld == 1'b0, "R10 idle gives no output", longint'(res_vld), 0);
                chk(q_bit == q || j == 0, "R10 q holds in idle", longint'(q_bit), longint'(q));
            end
        end
    endtask

    // One step checked against the bench model.
    task automatic step_check(input bit gfp, input bit a, input longint cs, input longint cc,
                              input longint b, input longint p, input int gap, input string req);
        longint rs, rc, c, e;
        bit q, eq;
        run_op(gfp, a, cs, cc, b, p, gap, rs, rc, q);
        if (gfp) begin
            c  = cs + cc + (a ? b : 0);
            eq = c[0];
            e  = (c + (eq ? p : 0)) >> 1;
            chk(rs + rc == e, req, rs + rc, e);
        end else begin
            c  = cs ^ cc ^ (a ? b : 0);
            eq = c[0];
            e  = (c ^ (eq ? p : 0)) >> 1;
            chk(rs == e, req, rs, e);
            chk(rc == 0, "R3 carry zero", rc, 0);
        end
        chk(q == eq, "R2 q parity", longint'(q), longint'(eq));
    endtask

    function automatic longint rnd(input int bits);
        longint v = {$urandom, $urandom};
        return v & ((longint'(1) << bits) - 1);
    endfunction

    initial begin
        longint rs, rc, cs, cc, a16, b16, p16;
        bit q;
        void'($urandom(32'h5EED_0C3A));
        rst_n = 1'b0; word_vld = 0; word_first = 0; gf_prime = 0; a_bit = 0;
        b_word = '1; p_word = '1; cs_word = '1; cc_word = '1;
        repeat (3) @(negedge clk);
        chk(res_vld == 0 && res_sum == 0 && res_carry == 0 && q_bit == 0,
            "R7 reset state", {res_vld, q_bit, res_sum, res_carry}, 0);
        rst_n = 1'b1;

        // Directed corners.
        step_check(1, 1, 0, 0, 0, 1, 0, "R1 zero operands");
        step_check(1, 1, 30'h3FFF_FFFF, 30'h3FFF_FFFF, 29'h1FFF_FFFF, 29'h1FFF_FFFF, 0, "R1 all ones");
        step_check(1, 0, 30'h1234_5677, 30'h0000_0001, 29'h1FFF_FFFF, 29'h0ABC_DEF1, 0, "R4 a=0 integer");
        step_check(0, 0, 30'h2AAA_AAA9, 30'h1555_5555, 29'h1FFF_FFFF, 29'h1000_0001, 0, "R4 a=0 polynomial");
        step_check(0, 1, 30'h3FFF_FFFF, 0, 30'h3FFF_FFFF, 30'h3FFF_FFFF, 0, "R3 all ones");

        // Random single steps, back to back, with and without idle gaps.
        for (int i = 0; i < 40; i++)
            step_check(1, $urandom_range(0, 1), rnd(29), rnd(29), rnd(29), rnd(29) | 1,
                       (i % 3 == 0) ? $urandom_range(1, 2) : 0,
                       (i % 3 == 0) ? "R10 R1 integer with gaps" : "R6 R1 integer back to back");
        for (int i = 0; i < 40; i++)
            step_check(0, $urandom_range(0, 1), rnd(30), rnd(30), rnd(30), rnd(30) | 1,
                       (i % 3 == 0) ? $urandom_range(1, 2) : 0,
                       (i % 3 == 0) ? "R10 R3 polynomial with gaps" : "R6 R3 polynomial back to back");

        // Chained integer Montgomery product.
        for (int t = 0; t < 3; t++) begin
            p16 = rnd(16) | 64'h8001; b16 = rnd(16) % p16; a16 = rnd(16);
            cs = 0; cc = 0;
            for (int i = 0; i < 16; i++) begin
                run_op(1, a16[i], cs, cc, b16, p16, 0, rs, rc, q);
                cs = rs; cc = rc;
            end
            chk((((cs + cc) % p16) << 16) % p16 == (a16 * b16) % p16, "R8 chained integer",
                (((cs + cc) % p16) << 16) % p16, (a16 * b16) % p16);
        end

        // Chained polynomial Montgomery product.
        for (int t = 0; t < 3; t++) begin
            p16 = rnd(16) | 64'h10001; b16 = rnd(16); a16 = rnd(16);
            cs = 0;
            for (int i = 0; i < 16; i++) begin
                run_op(0, a16[i], cs, 0, b16, p16, 0, rs, rc, q);
                chk(rc == 0, "R3 chained carry zero", rc, 0);
                cs = rs;
            end
            chk(pmod(clmul(cs, 64'h10000), p16, 16) == pmod(clmul(a16, b16), p16, 16),
                "R9 chained polynomial", pmod(clmul(cs, 64'h10000), p16, 16),
                pmod(clmul(a16, b16), p16, 16));
        end

        word_vld = 0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule